// File: doc/BRIEF.md
# Block Transfer Sequencer for an External Frame Memory

This block moves a block of data between a 2 GiB external memory region and a host-side buffer. It does this as a series of fixed 8 KiB bursts on a simple request/acknowledge memory port. A host model supplies the following at each step strobe:
- a read offset and a write offset;
- a direction;
- a byte length;
- a trigger.

The block clears the low six bits of both offsets. It rounds the length up to whole bursts and rejects any request whose span would run past the top of the memory. For an accepted request it issues the read bursts first. When the direction includes a write, the write bursts follow, so the old contents at an offset are returned before they are overwritten. A read phase always takes place, whatever the direction.

Two completion policies are selectable per request:
- **Step-deferred:** the result is reported at the next step strobe.
- **Same-step:** the result is reported as soon as the last burst is acknowledged. A cycle budget cancels the transfer if it runs out.

A failure under the strict policy locks the block in a halt state until reset. Under the lenient policy a failure only reports a zero status.

Controller states:
- `ST_IDLE`: waiting for a step strobe with the trigger set.
- `ST_RD`: read bursts.
- `ST_WR`: write bursts.
- `ST_HOLD`: finished, waiting for the step strobe that reports it.
- `ST_HALT`: sticky error.

Transitions:
- IDLE→RD: accepted request.
- IDLE→IDLE or IDLE→HALT: overrun, lenient or strict.
- RD→WR: last read acknowledged and a write is requested.
- RD or WR → IDLE: finished in same-step mode, finished on a step, finished after a lenient late report, or a lenient timeout.
- RD or WR → HOLD: finished early in step-deferred mode.
- RD or WR → HALT: strict failure.
- HOLD→IDLE: next step strobe.

Top module: `fbuf_xfer_seq`

## Requirements
- R1: Each memory address equals the offset with bits [5:0] cleared plus k·0x2000 for burst k = 0, 1, 2, and so on.
- R2: The burst count is ceil(length/0x2000), with a minimum of one. Each burst holds `mem_req_o`, the address and `mem_we_o` steady until `mem_ack_i`.
- R3: A request is an overrun when aligned offset + count·0x2000 exceeds 2^31 for the read offset, or for the write offset when writing. An overrun makes no memory access and gives `done_o`=1, `status_o`=0 and `err_ovr_o`=1 one cycle after the accepting edge. A span ending exactly at 2^31 is legal.
- R4: Direction is encoded as 0 = read only, 1 = write only, 2 or 3 = read and write. Every request performs all read bursts (`mem_we_o`=0) first. For codes 1 to 3, all write bursts (`mem_we_o`=1) follow.
- R5: In step-deferred mode (`accel_i`=0), a transfer that finishes before the next step strobe gives no `done_o` until that strobe. It then gives `done_o`=1 and `status_o`=1 one cycle after the strobe edge.
- R6: In step-deferred lenient mode, a transfer still running at the next step strobe gives `done_o`=1 and `status_o`=0 one cycle later. It keeps `busy_o` high, completes its remaining bursts, and ends without a second `done_o`.
- R7: In same-step mode (`accel_i`=1), `done_o`=1 and `status_o`=1 appear the cycle after the final acknowledge.
- R8: In same-step mode, a transfer not finished within `timeout_i` cycles of bus activity is cancelled. `done_o`=1 and `status_o`=0 are reported, and `mem_req_o` falls.
- R9: With `strict_i`=1, any failure (overrun, timeout or late step) drives `halted_o` high until reset. While halted, triggers start nothing and `mem_req_o` stays low.
- R10: A trigger on a step strobe while `busy_o` is high is ignored and pulses `err_busy_o` for one cycle.
- R11: A transfer starts only on a cycle with `step_i`=1 and `trigger_i`=1 while idle. `busy_o` is high from the following cycle until the end of the transfer.
- R12: After reset, `busy_o`, `mem_req_o`, `done_o`, `status_o`, `halted_o` and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Model step strobe |
| trigger_i | input | 1 | Start request, sampled on step strobes |
| dir_i | input | 2 | Direction code |
| rd_ofs_i | input | 32 | Read offset in bytes |
| wr_ofs_i | input | 32 | Write offset in bytes |
| len_i | input | 24 | Transfer length in bytes |
| accel_i | input | 1 | 1 = same-step completion, 0 = step-deferred |
| strict_i | input | 1 | 1 = failures halt the block |
| timeout_i | input | 16 | Same-step cycle budget |
| mem_req_o | output | 1 | Burst request |
| mem_we_o | output | 1 | Burst is a write |
| mem_addr_o | output | 31 | Burst start address |
| mem_ack_i | input | 1 | Burst acknowledge |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion report |
| status_o | output | 1 | Result of the last report, 1 = completed |
| halted_o | output | 1 | Sticky strict-mode error |
| err_ovr_o | output | 1 | One-cycle overrun pulse |
| err_busy_o | output | 1 | One-cycle ignored-trigger pulse |

## Verification
A controller that leaves the read phase early or skips the write phase shows up on the next acknowledged burst. The scoreboard pops an expected address and direction for every acknowledge, so a wrong burst counter or base register is caught within one burst. A corrupted completion path shows up as a missing, early or duplicated `done_o`, or a wrong `status_o`, at the one cycle the requirement fixes: the cycle after the step edge or after the final acknowledge. A lost halt or a stale busy state is seen at the very next step strobe, as an access the scoreboard did not expect or a `busy_o` level that disagrees with the expected one.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;

    typedef enum logic [1:0] {
        DIR_RD = 2'd0,
        DIR_WR = 2'd1,
        DIR_RW = 2'd2
    } fb_dir_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_WR   = 3'd2,
        ST_HOLD = 3'd3,
        ST_HALT = 3'd4
    } fb_state_e;

endpackage

// File: rtl/fbuf_span_chk.sv
module fbuf_span_chk #(
    parameter int OFS_W    = 32,
    parameter int ADDR_W   = 31,
    parameter int LEN_W    = 24,
    parameter int BURST_LG = 13,
    parameter int ALIGN_LG = 6,
    parameter int NB_W     = LEN_W - BURST_LG + 1
) (
    input  logic [OFS_W-1:0]  rd_ofs_i,
    input  logic [OFS_W-1:0]  wr_ofs_i,
    input  logic              wr_en_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] rd_base_o,
    output logic [ADDR_W-1:0] wr_base_o,
    output logic [NB_W-1:0]   nburst_o,
    output logic              overrun_o
);
    localparam int SUM_W = OFS_W + 2;
    localparam logic [OFS_W-1:0] ALIGN_MASK = ~((OFS_W'(1) << ALIGN_LG) - OFS_W'(1));
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'(1) << ADDR_W;

    logic [OFS_W-1:0] rd_al, wr_al;
    logic [NB_W-1:0]  nb_raw;
    logic [SUM_W-1:0] span, rd_end, wr_end;

    always_comb begin
        rd_al    = rd_ofs_i & ALIGN_MASK;
        wr_al    = wr_ofs_i & ALIGN_MASK;
        nb_raw   = NB_W'(len_i >> BURST_LG) + NB_W'(|len_i[BURST_LG-1:0]);
        nburst_o = (nb_raw == '0) ? NB_W'(1) : nb_raw;
        span     = SUM_W'(nburst_o) << BURST_LG;
        rd_end   = SUM_W'(rd_al) + span;
        wr_end   = SUM_W'(wr_al) + span;
        overrun_o = (rd_end > LIMIT) || (wr_en_i && (wr_end > LIMIT));
        rd_base_o = rd_al[ADDR_W-1:0];
        wr_base_o = wr_al[ADDR_W-1:0];
    end
endmodule

// File: rtl/fbuf_burst_ctr.sv
module fbuf_burst_ctr #(
    parameter int ADDR_W   = 31,
    parameter int BURST_LG = 13,
    parameter int NB_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [NB_W-1:0]   count_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << BURST_LG;

    logic [NB_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            rem_q  <= '0;
        end else if (load_i) begin
            addr_o <= base_i;
            rem_q  <= count_i;
        end else if (adv_i) begin
            addr_o <= addr_o + STEP;
            rem_q  <= rem_q - NB_W'(1);
        end
    end

    assign last_o = (rem_q == NB_W'(1));

    // R2: never step past the final burst
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !load_i |-> rem_q > NB_W'(1));
endmodule

// File: rtl/fbuf_tmo_timer.sv
module fbuf_tmo_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [TMO_W-1:0] limit_i,
    input  logic             run_i,
    output logic             hit_o
);
    logic [TMO_W-1:0] cnt_q, lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (start_i) begin
            cnt_q <= '0;
            lim_q <= limit_i;
        end else if (run_i && (cnt_q != lim_q)) begin
            cnt_q <= cnt_q + TMO_W'(1);
        end
    end

    assign hit_o = (cnt_q == lim_q);

    // R8: the counter never passes its budget
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i && $past(cnt_q == lim_q) && !$past(start_i) |-> cnt_q == lim_q);
endmodule

// File: rtl/fbuf_xfer_seq.sv
module fbuf_xfer_seq
    import fbuf_pkg::*;
#(
    parameter int OFS_W    = 32,
    parameter int ADDR_W   = 31,
    parameter int LEN_W    = 24,
    parameter int TMO_W    = 16,
    parameter int BURST_LG = 13,
    parameter int ALIGN_LG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              trigger_i,
    input  logic [1:0]        dir_i,
    input  logic [OFS_W-1:0]  rd_ofs_i,
    input  logic [OFS_W-1:0]  wr_ofs_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              accel_i,
    input  logic              strict_i,
    input  logic [TMO_W-1:0]  timeout_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_ack_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              status_o,
    output logic              halted_o,
    output logic              err_ovr_o,
    output logic              err_busy_o
);
    localparam int NB_W = LEN_W - BURST_LG + 1;

    fb_state_e st, st_nx;

    logic              wr_q, accel_q, strict_q, late_q;
    logic [ADDR_W-1:0] wr_base_q;
    logic [NB_W-1:0]   nb_q;

    logic              dir_wr;
    logic [ADDR_W-1:0] sp_rd_base, sp_wr_base;
    logic [NB_W-1:0]   sp_nb;
    logic              sp_ovr;

    logic              bc_load, bc_adv, bc_last;
    logic [ADDR_W-1:0] bc_base, bc_addr;
    logic [NB_W-1:0]   bc_cnt;
    logic              tmo_hit;

    logic accept, on_bus, ack_last, fin, to_wr, fail_now;
    logic ev_done, ev_ok, ev_ovr, ev_busy, set_late;

    assign dir_wr = (dir_i != DIR_RD);

    fbuf_span_chk #(
        .OFS_W(OFS_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
        .BURST_LG(BURST_LG), .ALIGN_LG(ALIGN_LG), .NB_W(NB_W)
    ) u_span (
        .rd_ofs_i (rd_ofs_i),
        .wr_ofs_i (wr_ofs_i),
        .wr_en_i  (dir_wr),
        .len_i    (len_i),
        .rd_base_o(sp_rd_base),
        .wr_base_o(sp_wr_base),
        .nburst_o (sp_nb),
        .overrun_o(sp_ovr)
    );

    fbuf_burst_ctr #(
        .ADDR_W(ADDR_W), .BURST_LG(BURST_LG), .NB_W(NB_W)
    ) u_bctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (bc_load),
        .base_i (bc_base),
        .count_i(bc_cnt),
        .adv_i  (bc_adv),
        .addr_o (bc_addr),
        .last_o (bc_last)
    );

    fbuf_tmo_timer #(
        .TMO_W(TMO_W)
    ) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(accept),
        .limit_i(timeout_i),
        .run_i  (on_bus),
        .hit_o  (tmo_hit)
    );

    // decode of the current state
    always_comb begin
        on_bus   = (st == ST_RD) || (st == ST_WR);
        busy_o   = on_bus || (st == ST_HOLD);
        halted_o = (st == ST_HALT);
        accept   = step_i && trigger_i && (st == ST_IDLE);
        ev_busy  = step_i && trigger_i && busy_o;
        ack_last = on_bus && mem_ack_i && bc_last;
        to_wr    = (st == ST_RD) && ack_last && wr_q;
        fin      = ack_last && ((st == ST_WR) || !wr_q);
        fail_now = accel_q ? tmo_hit : (step_i && !late_q);
        bc_load  = (accept && !sp_ovr) || to_wr;
        bc_base  = (st == ST_IDLE) ? sp_rd_base : wr_base_q;
        bc_cnt   = (st == ST_IDLE) ? sp_nb : nb_q;
        bc_adv   = on_bus && mem_ack_i && !bc_last;
        mem_req_o  = on_bus;
        mem_we_o   = (st == ST_WR);
        mem_addr_o = bc_addr;
    end

    // next state and step events
    always_comb begin
        st_nx    = st;
        ev_done  = 1'b0;
        ev_ok    = 1'b0;
        ev_ovr   = 1'b0;
        set_late = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (accept) begin
                    if (sp_ovr) begin
                        ev_done = 1'b1;
                        ev_ovr  = 1'b1;
                        st_nx   = strict_i ? ST_HALT : ST_IDLE;
                    end else begin
                        st_nx = ST_RD;
                    end
                end
            end
            ST_RD, ST_WR: begin
                if (fin) begin
                    if (late_q) begin
                        st_nx = ST_IDLE;
                    end else if (accel_q || step_i) begin
                        ev_done = 1'b1;
                        ev_ok   = 1'b1;
                        st_nx   = ST_IDLE;
                    end else begin
                        st_nx = ST_HOLD;
                    end
                end else begin
                    st_nx = to_wr ? ST_WR : st;
                    if (fail_now) begin
                        ev_done = 1'b1;
                        if (strict_q)     st_nx = ST_HALT;
                        else if (accel_q) st_nx = ST_IDLE;
                        else              set_late = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (step_i) begin
                    ev_done = 1'b1;
                    ev_ok   = 1'b1;
                    st_nx   = ST_IDLE;
                end
            end
            ST_HALT: st_nx = ST_HALT;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register and per-request configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            wr_q      <= 1'b0;
            accel_q   <= 1'b0;
            strict_q  <= 1'b0;
            late_q    <= 1'b0;
            wr_base_q <= '0;
            nb_q      <= '0;
        end else begin
            st <= st_nx;
            if (accept) begin
                wr_q      <= dir_wr;
                accel_q   <= accel_i;
                strict_q  <= strict_i;
                late_q    <= 1'b0;
                wr_base_q <= sp_wr_base;
                nb_q      <= sp_nb;
            end else if (set_late) begin
                late_q <= 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            status_o   <= 1'b0;
            err_ovr_o  <= 1'b0;
            err_busy_o <= 1'b0;
        end else begin
            done_o     <= ev_done;
            err_ovr_o  <= ev_ovr;
            err_busy_o <= ev_busy;
            if (ev_done) status_o <= ev_ok;
        end
    end

    // R1: burst addresses keep the offset alignment
    a_r1_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> mem_addr_o[ALIGN_LG-1:0] == '0);

    // R2: a pending burst holds until acknowledged or the transfer is reported
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)) || done_o);

    // R3: an overrun is always reported as a failed completion
    a_r3_ovr_fail: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovr_o |-> done_o && !status_o && !mem_req_o);

    // R9: the halt is sticky and silent
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o);
    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !mem_req_o && !busy_o);

    // R10: an ignored-trigger flag follows a busy cycle
    a_r10_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
        err_busy_o |-> $past(busy_o));

    // R4: a write burst is never followed directly by a read burst
    a_r4_rd_first: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |=> !(mem_req_o && !mem_we_o));
endmodule

// File: tb/sim_fbuf_xfer_seq.sv
module sim_fbuf_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0, trigger_i = 1'b0;
    logic [1:0]  dir_i = 2'd0;
    logic [31:0] rd_ofs_i = '0, wr_ofs_i = '0;
    logic [23:0] len_i = '0;
    logic        accel_i = 1'b0, strict_i = 1'b0;
    logic [15:0] timeout_i = '0;
    logic        mem_req_o, mem_we_o, mem_ack_i = 1'b0;
    logic [30:0] mem_addr_o;
    logic        busy_o, done_o, status_o, halted_o, err_ovr_o, err_busy_o;

    always #10 clk = ~clk;

    fbuf_xfer_seq u0 (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .trigger_i(trigger_i),
        .dir_i(dir_i), .rd_ofs_i(rd_ofs_i), .wr_ofs_i(wr_ofs_i), .len_i(len_i),
        .accel_i(accel_i), .strict_i(strict_i), .timeout_i(timeout_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_ack_i(mem_ack_i), .busy_o(busy_o), .done_o(done_o),
        .status_o(status_o), .halted_o(halted_o), .err_ovr_o(err_ovr_o),
        .err_busy_o(err_busy_o)
    );

    typedef struct packed { logic we; logic [30:0] addr; } acc_t;
    acc_t expq[$];
    int n_chk = 0, n_fail = 0;
    int ack_lat = 0, wcnt = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack_i = 1'b0;
            wcnt = 0;
        end else if (mem_ack_i) begin
            mem_ack_i = 1'b0;
            wcnt = 0;
        end else if (mem_req_o) begin
            if (wcnt >= ack_lat) begin
                acc_t e;
                mem_ack_i = 1'b1;
                if (expq.size() == 0) begin
                    check(1'b0, "R2 unexpected access", longint'({mem_we_o, mem_addr_o}), 0);
                end else begin
                    e = expq.pop_front();
                    check(e == {mem_we_o, mem_addr_o}, "R1 R4 burst order/address",
                          longint'({mem_we_o, mem_addr_o}), longint'(e));
                end
            end else begin
                wcnt++;
            end
        end else begin
            wcnt = 0;
        end
    end

    task automatic set_req(input logic [1:0] d, input logic [31:0] ro, input logic [31:0] wo,
                           input logic [23:0] l, input bit acc, input bit str, input int tmo);
        dir_i = d; rd_ofs_i = ro; wr_ofs_i = wo; len_i = l;
        accel_i = acc; strict_i = str; timeout_i = 16'(tmo);
    endtask

    task automatic push_exp(input logic [1:0] d, input logic [31:0] ro, input logic [31:0] wo,
                            input logic [23:0] l);
        int nb;
        nb = (l == 0) ? 1 : (int'(l) + 8191) / 8192;
        for (int k = 0; k < nb; k++) expq.push_back({1'b0, 31'((ro & ~32'h3f) + 32'(k * 8192))});
        if (d != 2'd0)
            for (int k = 0; k < nb; k++) expq.push_back({1'b1, 31'((wo & ~32'h3f) + 32'(k * 8192))});
    endtask

    task automatic pulse_step(input bit trig);
        @(negedge clk); step_i = 1'b1; trigger_i = trig;
        @(negedge clk); step_i = 1'b0; trigger_i = 1'b0;
    endtask

    task automatic wait_done(input int maxc, output bit seen, output bit st);
        seen = 1'b0; st = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (done_o) begin seen = 1'b1; st = status_o; break; end
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        bit seen, st;
        int ndone;
        repeat (3) @(negedge clk);
        // R12 reset state
        check({busy_o, mem_req_o, done_o, status_o, halted_o, err_ovr_o, err_busy_o} == 7'b0,
              "R12 reset outputs", {busy_o, mem_req_o, done_o, status_o, halted_o, err_ovr_o, err_busy_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7 R1 same-step read, misaligned offset, short length
        ack_lat = 2;
        set_req(2'd0, 32'h0012_3457, 32'h0, 24'd100, 1'b1, 1'b0, 200);
        push_exp(2'd0, 32'h0012_3457, 32'h0, 24'd100);
        pulse_step(1'b1);
        check(busy_o == 1'b1, "R11 busy after accepted trigger", busy_o, 1);
        wait_done(100, seen, st);
        check(seen && st, "R7 same-step completion", {seen, st}, 3);
        check(expq.size() == 0, "R2 single burst for short length", expq.size(), 0);

        // R4 R2 read then write, three bursts each
        ack_lat = 0;
        set_req(2'd2, 32'h0040_0000, 32'h0080_0041, 24'h4001, 1'b1, 1'b0, 500);
        push_exp(2'd2, 32'h0040_0000, 32'h0080_0041, 24'h4001);
        pulse_step(1'b1);
        wait_done(200, seen, st);
        check(seen && st, "R4 read/write completion", {seen, st}, 3);
        check(expq.size() == 0, "R2 burst count rounding", expq.size(), 0);

        // R4 write-only still reads first, zero length
        set_req(2'd1, 32'h0000_1000, 32'h0000_3000, 24'd0, 1'b1, 1'b0, 500);
        push_exp(2'd1, 32'h0000_1000, 32'h0000_3000, 24'd0);
        pulse_step(1'b1);
        wait_done(100, seen, st);
        check(seen && st && expq.size() == 0, "R4 write-only performs read", expq.size(), 0);

        // R5 step-deferred success
        ack_lat = 1;
        set_req(2'd0, 32'h0000_2000, 32'h0, 24'd8192, 1'b0, 1'b0, 0);
        push_exp(2'd0, 32'h0000_2000, 32'h0, 24'd8192);
        pulse_step(1'b1);
        ndone = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (done_o) ndone++; end
        check(ndone == 0 && busy_o, "R5 no report before next step", ndone, 0);
        check(expq.size() == 0, "R5 transfer finished early", expq.size(), 0);
        pulse_step(1'b0);
        check(done_o && status_o, "R5 report on next step", {done_o, status_o}, 3);
        @(negedge clk);
        check(!busy_o, "R5 idle after report", busy_o, 0);

        // R6 R10 step-deferred lenient late transfer
        ack_lat = 30;
        set_req(2'd0, 32'h0001_0000, 32'h0, 24'd24576, 1'b0, 1'b0, 0);
        push_exp(2'd0, 32'h0001_0000, 32'h0, 24'd24576);
        pulse_step(1'b1);
        repeat (5) @(negedge clk);
        pulse_step(1'b1);
        check(done_o && !status_o, "R6 late transfer reported failed", {done_o, status_o}, 2);
        check(err_busy_o, "R10 trigger while busy flagged", err_busy_o, 1);
        check(busy_o, "R6 transfer continues after report", busy_o, 1);
        ndone = 0;
        for (int i = 0; i < 300 && busy_o; i++) begin @(negedge clk); if (done_o) ndone++; end
        check(!busy_o && ndone == 0, "R6 silent completion", ndone, 0);
        check(expq.size() == 0, "R6 all bursts completed", expq.size(), 0);

        // R11 trigger without a step and step without a trigger
        ack_lat = 0;
        trigger_i = 1'b1;
        repeat (5) @(negedge clk);
        trigger_i = 1'b0;
        pulse_step(1'b0);
        check(!busy_o && !done_o, "R11 no start without step and trigger", busy_o, 0);

        // R3 read overrun
        set_req(2'd0, 32'h7FFF_F03F, 32'h0, 24'd1, 1'b1, 1'b0, 100);
        pulse_step(1'b1);
        check(done_o && !status_o && err_ovr_o, "R3 read overrun rejected",
              {done_o, status_o, err_ovr_o}, 5);
        check(!busy_o, "R3 no transfer after overrun", busy_o, 0);

        // R3 exact end of space is legal
        set_req(2'd0, 32'h7FFF_E000, 32'h0, 24'd8192, 1'b1, 1'b0, 100);
        push_exp(2'd0, 32'h7FFF_E000, 32'h0, 24'd8192);
        pulse_step(1'b1);
        wait_done(50, seen, st);
        check(seen && st && !err_ovr_o && expq.size() == 0, "R3 span ending at top accepted",
              {seen, st}, 3);

        // R3 write offset overrun blocks the read too
        set_req(2'd2, 32'h0, 32'h7FFF_F000, 24'd4096, 1'b1, 1'b0, 100);
        pulse_step(1'b1);
        check(done_o && !status_o && err_ovr_o, "R3 write overrun rejected",
              {done_o, status_o, err_ovr_o}, 5);

        // R8 same-step timeout, lenient
        ack_lat = 100000;
        set_req(2'd0, 32'h0, 32'h0, 24'd8192, 1'b1, 1'b0, 20);
        pulse_step(1'b1);
        wait_done(60, seen, st);
        check(seen && !st, "R8 timeout reported failed", {seen, st}, 2);
        @(negedge clk);
        check(!mem_req_o && !busy_o && !halted_o, "R8 transfer cancelled",
              {mem_req_o, busy_o, halted_o}, 0);

        // R9 strict timeout halts
        set_req(2'd0, 32'h0, 32'h0, 24'd8192, 1'b1, 1'b1, 20);
        pulse_step(1'b1);
        wait_done(60, seen, st);
        check(seen && !st, "R9 strict failure reported", {seen, st}, 2);
        @(negedge clk);
        check(halted_o, "R9 halt raised", halted_o, 1);
        ack_lat = 0;
        set_req(2'd0, 32'h0000_4000, 32'h0, 24'd100, 1'b1, 1'b0, 100);
        pulse_step(1'b1);
        repeat (10) @(negedge clk);
        check(halted_o && !busy_o && !mem_req_o, "R9 halted block ignores triggers",
              {halted_o, busy_o, mem_req_o}, 4);

        check(expq.size() == 0, "R2 scoreboard drained", expq.size(), 0);
        finish_run();
    end
endmodule